// File: doc/BRIEF.md
# Page Write Collector with Address Sequencing and Upper-Quarter Lock

This block sits between a two-wire serial memory controller and its 8192-byte storage array. It keeps the 13-bit word address. The controller loads that address from two address bytes and steps it once per data byte. The stepping rule depends on the transfer direction. On a write, only the 5-bit offset inside the 32-byte page advances, and it wraps back to the start of the same page. On a read, the whole address advances, and it wraps from the last byte of the array to byte 0.

Data bytes that arrive in write mode are held in a 32-entry page buffer. A per-offset valid mask records which offsets were written. When the controller signals that the self-timed write cycle starts, the block scans the buffer once, from offset 0 up to offset 31. It issues one array write for each valid offset, at the page taken from the word address at that moment, and then clears the mask. If the write-control input is high and the page lies in the top quarter of the array, the block drops the buffer without writing anything and finishes after a single busy cycle. While busy, the block ignores every strobe.

States: `ST_IDLE` (accepts strobes), `ST_SCAN` (32 cycles, one offset per cycle), `ST_DISCARD` (1 cycle, protected commit). Transitions: `ST_IDLE -> ST_SCAN` on an unprotected commit, `ST_IDLE -> ST_DISCARD` on a protected commit, `ST_SCAN -> ST_IDLE` after offset 31, `ST_DISCARD -> ST_IDLE` unconditionally.

Top module: `page_commit_unit`

## Requirements
- R1: While reset is asserted and just after it is released, `word_addr` is 0, `busy` is 0 and `arr_we` is 0.
- R2: When idle, `ld_hi` loads `word_addr[12:8]` from `din[4:0]` and ignores `din[7:5]`. `ld_lo` loads `word_addr[7:0]` from `din`. Both take effect on the following cycle.
- R3: An idle `step` with `wr_mode`=1 stores `din` into the buffer slot at offset `word_addr[4:0]`. It then advances only `word_addr[4:0]`, wrapping 31 to 0. `word_addr[12:5]` is unchanged, so after a write the address is the last written offset plus one, within the same page.
- R4: An idle `step` with `wr_mode`=0 increments the full 13-bit `word_addr`, wrapping 0x1FFF to 0x0000, whatever the level of `wc`.
- R5: When more than 32 bytes are written to one page, a later byte at an offset replaces the earlier one. Only the last value for each offset is committed.
- R6: An unprotected idle `commit` holds `busy` high for exactly 32 cycles. During that time `arr_we` pulses once for each buffered offset, in ascending offset order, with `arr_waddr` = {page at commit, offset} and `arr_wdata` = the buffered byte.
- R7: An idle `commit` with `wc`=1 and `word_addr[12:11]`=2'b11 (addresses 0x1800-0x1FFF) produces no `arr_we`, holds `busy` high for exactly 1 cycle and discards the buffered bytes.
- R8: With `wc`=0 the top quarter is written normally. With `wc`=1 pages below 0x1800 are written normally.
- R9: While `busy` is high, `ld_hi`, `ld_lo`, `step` and `commit` have no effect.
- R10: After every commit the valid mask is empty, so a second commit with no new bytes writes nothing.
- R11: On one idle cycle, `commit` takes priority over the loads, and the loads take priority over `step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | 1 = write transfer, 0 = read transfer |
| ld_hi | input | 1 | Load high address byte from `din` |
| ld_lo | input | 1 | Load low address byte from `din` |
| step | input | 1 | One data byte done; in write mode `din` is buffered |
| din | input | 8 | Address or data byte |
| commit | input | 1 | Start of the internal write cycle |
| wc | input | 1 | Write control; high locks the top quarter (tie low when unused) |
| word_addr | output | 13 | Current word address, also the array read address |
| busy | output | 1 | Commit or discard in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_waddr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bound checker watches these on every cycle:
- `arr_we` never appears outside `busy`.
- The write page stays fixed through a scan.
- The address holds across every busy edge.
- A read step advances the full address by one, and a write step leaves the page bits alone.
- A protected commit produces exactly one busy cycle with no write.

The bench's scenarios are needed for the rest:
- Which offsets are written, in what order and with what data.
- Overwrite on page wrap.
- The exact 32-cycle busy length.
- The mask clearing between commits.
- Priority among simultaneous strobes.
- The `wc` level paired with both halves of the array.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SCAN    = 2'd1,
        ST_DISCARD = 2'd2
    } pcu_state_t;
endpackage

// File: rtl/pcu_addr_ctr.sv
module pcu_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              step,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_q;

    // Write steps stay inside the page; read steps roll over the whole array.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            if (ld_hi) addr_q[ADDR_W-1:DATA_W] <= din[HI_W-1:0];
            if (ld_lo) addr_q[DATA_W-1:0]      <= din;
            if (step) begin
                if (wr_mode) addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + 1'b1;
                else         addr_q            <= addr_q + 1'b1;
            end
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/pcu_page_buf.sv
module pcu_page_buf #(
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] din,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SLOTS = 1 << OFF_W;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  valid_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == OFF_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q[g] <= '0;
            else if (hit) slot_q[g] <= din;
        end

        // Clearing wins: the block never writes and clears in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    valid_q[g] <= 1'b0;
            else if (clr)  valid_q[g] <= 1'b0;
            else if (hit)  valid_q[g] <= 1'b1;
        end
    end

    assign rd_data  = slot_q[rd_off];
    assign rd_valid = valid_q[rd_off];
endmodule

// File: rtl/pcu_commit_fsm.sv
module pcu_commit_fsm
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    blocked,
    input  logic [ADDR_W-OFF_W-1:0] page_in,
    output logic                    busy,
    output logic                    scan_act,
    output logic                    mask_clr,
    output logic [OFF_W-1:0]        scan_off,
    output logic [ADDR_W-OFF_W-1:0] page
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    pcu_state_t        state_q, state_d;
    logic [OFF_W-1:0]  off_q;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = blocked ? ST_DISCARD : ST_SCAN;
            ST_SCAN:    if (off_q == LAST_OFF) state_d = ST_IDLE;
            ST_DISCARD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            page_q <= '0;
        end else begin
            off_q <= (state_q == ST_SCAN) ? off_q + 1'b1 : '0;
            if (state_q == ST_IDLE && start) page_q <= page_in;
        end
    end

    always_comb begin
        busy     = 1'b0;
        scan_act = 1'b0;
        mask_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: begin
                busy     = 1'b1;
                scan_act = 1'b1;
                mask_clr = (off_q == LAST_OFF);
            end
            ST_DISCARD: begin
                busy     = 1'b1;
                mask_clr = 1'b1;
            end
            default: ;
        endcase
    end

    assign scan_off = off_q;
    assign page     = page_q;
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8,
    parameter int PROT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              step,
    input  logic [DATA_W-1:0] din,
    input  logic              commit,
    input  logic              wc,
    output logic [ADDR_W-1:0] word_addr,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              idle;
    logic              do_commit, do_hi, do_lo, do_step, buf_we;
    logic              prot_hit;
    logic              scan_act, mask_clr, rd_valid;
    logic [OFF_W-1:0]  scan_off;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] addr;

    // Strobe arbitration: commit first, then address loads, then data steps.
    assign idle      = !busy;
    assign do_commit = idle && commit;
    assign do_hi     = idle && !commit && ld_hi;
    assign do_lo     = idle && !commit && ld_lo;
    assign do_step   = idle && !commit && !ld_hi && !ld_lo && step;
    assign buf_we    = do_step && wr_mode;
    assign prot_hit  = wc && (&addr[ADDR_W-1 -: PROT_W]);

    pcu_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (do_hi),
        .ld_lo   (do_lo),
        .step    (do_step),
        .wr_mode (wr_mode),
        .din     (din),
        .addr    (addr)
    );

    pcu_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_off   (addr[OFF_W-1:0]),
        .din      (din),
        .clr      (mask_clr),
        .rd_off   (scan_off),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    pcu_commit_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (do_commit),
        .blocked  (prot_hit),
        .page_in  (addr[ADDR_W-1:OFF_W]),
        .busy     (busy),
        .scan_act (scan_act),
        .mask_clr (mask_clr),
        .scan_off (scan_off),
        .page     (page)
    );

    assign word_addr = addr;
    assign arr_we    = scan_act && rd_valid;
    assign arr_waddr = {page, scan_off};
    assign arr_wdata = rd_data;
endmodule

// File: rtl/page_commit_unit_chk.sv
module page_commit_unit_chk #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8,
    parameter int PROT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_mode,
    input logic              ld_hi,
    input logic              ld_lo,
    input logic              step,
    input logic              commit,
    input logic              wc,
    input logic [ADDR_W-1:0] word_addr,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr
);
    logic lone_step;
    assign lone_step = !busy && step && !commit && !ld_hi && !ld_lo;

    // R6
    we_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R6
    scan_page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_waddr[ADDR_W-1:OFF_W]));

    // R9
    addr_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_addr));

    // R4
    read_step_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_step && !wr_mode) |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1)));

    // R3
    write_step_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_step && wr_mode) |=> $stable(word_addr[ADDR_W-1:OFF_W]));

    // R7
    locked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit && wc && (&word_addr[ADDR_W-1 -: PROT_W])) |=> (busy && !arr_we));

    // R7
    locked_commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit && wc && (&word_addr[ADDR_W-1 -: PROT_W])) |=> ##1 !busy);
endmodule

bind page_commit_unit page_commit_unit_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .PROT_W(PROT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .step      (step),
    .commit    (commit),
    .wc        (wc),
    .word_addr (word_addr),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr)
);

// File: tb/page_commit_unit_tb_top.sv
`timescale 1ns/1ps
module page_commit_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_mode = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0, step = 1'b0;
    logic        commit = 1'b0, wc = 1'b0;
    logic [7:0]  din = '0;
    logic [12:0] word_addr, arr_waddr;
    logic        busy, arr_we;
    logic [7:0]  arr_wdata;

    always #2.5 clk = ~clk;

    page_commit_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .step(step), .din(din), .commit(commit), .wc(wc), .word_addr(word_addr),
        .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    int    n_vec = 0, n_bad = 0, n_wr = 0;
    string req = "R1";

    // Behavioural reference state
    logic [12:0] m_addr = '0;
    logic [7:0]  m_buf [32];
    bit          m_mask [32];
    int          m_busy = 0;
    logic [20:0] exp_q [$];

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (m_busy > 0) begin
            m_busy--;                                   // R9 strobes ignored
        end else if (commit) begin                      // R11 commit first
            if (wc && m_addr[12:11] == 2'b11) begin     // R7
                m_busy = 1;
            end else begin
                for (int o = 0; o < 32; o++)
                    if (m_mask[o]) exp_q.push_back({m_addr[12:5], 5'(o), m_buf[o]});
                m_busy = 32;
            end
            for (int o = 0; o < 32; o++) m_mask[o] = 0; // R10
        end else begin
            if (ld_hi) m_addr[12:8] = din[4:0];          // R2
            if (ld_lo) m_addr[7:0]  = din;
            if (!ld_hi && !ld_lo && step) begin
                if (wr_mode) begin                       // R3 / R5
                    m_buf[m_addr[4:0]]  = din;
                    m_mask[m_addr[4:0]] = 1;
                    m_addr[4:0] = m_addr[4:0] + 5'd1;
                end else begin
                    m_addr = m_addr + 13'd1;             // R4
                end
            end
        end
    endtask

    task automatic compare();
        logic [20:0] e;
        chk(word_addr == m_addr, "word_addr", word_addr, m_addr);
        chk(busy == (m_busy > 0), "busy", busy, m_busy > 0);
        if (arr_we) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                chk(0, "unexpected arr_we at", arr_waddr, 0);
            end else begin
                e = exp_q.pop_front();
                chk(arr_waddr == e[20:8], "arr_waddr", arr_waddr, e[20:8]);
                chk(arr_wdata == e[7:0], "arr_wdata", arr_wdata, e[7:0]);
            end
        end
        if (!busy && m_busy == 0 && exp_q.size() != 0) begin
            chk(0, "missing writes", 0, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        ld_hi = 1; din = hi; tick(); ld_hi = 0;
        ld_lo = 1; din = lo; tick(); ld_lo = 0;
    endtask

    task automatic wbyte(input logic [7:0] d);
        wr_mode = 1; step = 1; din = d; tick(); step = 0;
    endtask

    task automatic rstep();
        wr_mode = 0; step = 1; tick(); step = 0;
    endtask

    task automatic do_commit(input int expect_wr, input int expect_busy);
        int busy_cnt = 0;
        n_wr = 0;
        commit = 1; tick(); commit = 0;
        if (busy) busy_cnt++;
        for (int k = 0; k < 34; k++) begin
            tick();
            if (busy) busy_cnt++;
        end
        chk(n_wr == expect_wr, "write count", n_wr, expect_wr);
        chk(busy_cnt == expect_busy, "busy cycles", busy_cnt, expect_busy);
    endtask

    initial begin : watchdog
        #500000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int o = 0; o < 32; o++) begin m_buf[o] = '0; m_mask[o] = 0; end
        repeat (3) @(negedge clk);
        req = "R1";
        chk(word_addr == 0, "reset word_addr", word_addr, 0);
        chk(busy == 0, "reset busy", busy, 0);
        chk(arr_we == 0, "reset arr_we", arr_we, 0);
        rst_n = 1;
        tick();

        // R2: high byte keeps only bits 4:0
        req = "R2";
        load(8'hEA, 8'h1C);
        chk(word_addr == 13'h0A1C, "loaded address", word_addr, 13'h0A1C);

        // R3: page wrap on write, page bits fixed, address = last + 1
        req = "R3";
        for (int i = 0; i < 6; i++) wbyte(8'h40 + 8'(i));
        chk(word_addr == 13'h0A02, "address after write wrap", word_addr, 13'h0A02);

        // R6: ascending-offset commit of 6 masked bytes, 32 busy cycles
        req = "R6";
        do_commit(6, 32);

        // R10: mask cleared, second commit writes nothing
        req = "R10";
        do_commit(0, 32);

        // R4: read steps roll across the array end, wc has no effect
        req = "R4";
        wc = 1;
        load(8'h1F, 8'hFE);
        rstep();
        chk(word_addr == 13'h1FFF, "read step", word_addr, 13'h1FFF);
        rstep();
        chk(word_addr == 13'h0000, "read wrap", word_addr, 0);
        rstep();
        wc = 0;

        // R5: 35 bytes into one page, offsets 0..2 overwritten
        req = "R5";
        load(8'h04, 8'h00);
        for (int i = 0; i < 35; i++) wbyte(8'(i * 3));
        do_commit(32, 32);

        // R7: protected upper quarter is discarded in one busy cycle
        req = "R7";
        wc = 1;
        load(8'h18, 8'h05);
        wbyte(8'hAA); wbyte(8'hBB);
        do_commit(0, 1);
        wc = 0;
        req = "R10";
        do_commit(0, 32);

        // R8: wc low writes top quarter, wc high writes lower page
        req = "R8";
        load(8'h1F, 8'hE0);
        wbyte(8'h11);
        do_commit(1, 32);
        wc = 1;
        load(8'h17, 8'hFF);
        wbyte(8'h22); wbyte(8'h33);
        do_commit(2, 32);
        wc = 0;

        // R9: strobes during busy are ignored
        req = "R9";
        load(8'h02, 8'h10);
        wbyte(8'h5A);
        commit = 1; tick(); commit = 0;
        ld_hi = 1; din = 8'h07; tick(); ld_hi = 0;
        wr_mode = 1; step = 1; din = 8'h99; tick(); step = 0;
        commit = 1; tick(); commit = 0;
        for (int k = 0; k < 32; k++) tick();
        chk(word_addr == 13'h0211, "address after busy strobes", word_addr, 13'h0211);

        // R11: commit beats load, load beats step
        req = "R11";
        wbyte(8'h77);
        commit = 1; ld_hi = 1; din = 8'h05; tick(); commit = 0; ld_hi = 0;
        for (int k = 0; k < 32; k++) tick();
        chk(word_addr == 13'h0212, "commit over load", word_addr, 13'h0212);
        ld_lo = 1; step = 1; wr_mode = 0; din = 8'h40; tick(); ld_lo = 0; step = 0;
        chk(word_addr == 13'h0240, "load over step", word_addr, 13'h0240);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule